// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flag

This block is a 256-word by 18-bit first-in first-out buffer whose two sides run on unrelated clocks. A producer strobes words in with a write enable on the rising edge of the load clock. A consumer pulls words out with a read enable on the rising edge of the unload clock. The word that is read appears on the output register at that unload edge.

Both sides exchange their 9-bit positions as Gray code through two-stage synchronizers. The block reports four status outputs: an active-low full, an active-low empty, a half-full indication, and one combined "near a boundary" flag. The combined flag is high when the buffer is close to empty or close to full. The two thresholds behind the combined flag can be set after reset. Hold the program-enable input low during the first one or two write strobes, and the low byte of the write data is taken as the thresholds instead of being stored.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words are read out in the order they were written, with all 18 bits intact, and up to 256 words can be held at once.
- R2: After 256 more words have been written than read, full_n is 0. A write strobe while full changes neither the stored words nor the write position. full_n is 1 at any other count.
- R3: empty_n is 0 when no word is held. A read strobe while empty leaves rdata and the read position unchanged.
- R4: After the asynchronous active-high reset, empty_n is 0, full_n is 1, half_full is 0 and alm_flag is 1.
- R5: half_full is 1 exactly when the write-side count is 128 or more.
- R6: While prog_n is 0, the first write strobe after reset loads the low-end threshold X from wdata[7:0]. The second such strobe loads the high-end threshold Y from wdata[7:0]. Neither strobe stores a word. A strobe with prog_n at 1 ends the programming window.
- R7: alm_flag is 1 when the write-side count is at most X or at least 256-Y, and 0 when the count lies from X+1 to 255-Y.
- R8: If only one programming strobe occurs, Y takes the same value as X.
- R9: If no programming strobe occurs after reset, X and Y are both 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous reset, active high, for both sides |
| wclk | input | 1 | Load clock |
| wr_en | input | 1 | Write strobe, sampled on the rising edge of wclk |
| prog_n | input | 1 | Threshold programming enable, active low |
| wdata | input | 18 | Write data; bits 7:0 carry a threshold during programming |
| full_n | output | 1 | 0 when the buffer is full |
| half_full | output | 1 | 1 when 128 or more words are held |
| alm_flag | output | 1 | 1 when the count is near empty or near full |
| rclk | input | 1 | Unload clock |
| rd_en | input | 1 | Read strobe, sampled on the rising edge of rclk |
| rdata | output | 18 | Registered read data |
| empty_n | output | 1 | 0 when the buffer is empty |

## Verification
The assertions check four rules on every clock edge. The write position does not move on a strobe while full or on a programming strobe. The read position and rdata hold on a strobe while empty. The write-side count never exceeds the depth, and full always implies both half_full and alm_flag. Data ordering, the exact count at which each flag changes, the threshold loading sequence with its one-strobe and default variants, and the reset values can only be shown by the bench's directed scenarios. Those scenarios compare outputs against counts the bench tracks itself.

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int W       = 18,
  parameter int AW      = 8,
  parameter int OFS_W   = 8,
  parameter int DEF_OFS = 32
) (
  input  logic         rst,
  input  logic         wclk,
  input  logic         wr_en,
  input  logic         prog_n,
  input  logic [W-1:0] wdata,
  output logic         full_n,
  output logic         half_full,
  output logic         alm_flag,
  input  logic         rclk,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         empty_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);
  localparam logic [PW-1:0] HALF  = PW'(1 << (AW - 1));

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] mem [1 << AW];

  // write side
  logic [PW-1:0]    wptr, wgray, rg_s1, rg_s2;
  logic [PW-1:0]    rgray;
  logic [1:0]       pstate;
  logic [OFS_W-1:0] ofs_x, ofs_y;

  wire [PW-1:0] rptr_w   = g2b(rg_s2);
  wire [PW-1:0] wcount   = wptr - rptr_w;
  wire          prog_cyc = wr_en && !prog_n && (pstate != 2'd2);
  wire          do_wr    = wr_en && !prog_cyc && (wcount != DEPTH);

  always_ff @(posedge wclk or posedge rst) begin
    if (rst) begin
      wptr   <= '0;
      wgray  <= '0;
      rg_s1  <= '0;
      rg_s2  <= '0;
      pstate <= 2'd0;
      ofs_x  <= OFS_W'(DEF_OFS);
      ofs_y  <= OFS_W'(DEF_OFS);
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (prog_cyc) begin
        if (pstate == 2'd0) begin
          ofs_x  <= wdata[OFS_W-1:0];
          ofs_y  <= wdata[OFS_W-1:0];
          pstate <= 2'd1;
        end else begin
          ofs_y  <= wdata[OFS_W-1:0];
          pstate <= 2'd2;
        end
      end else if (wr_en) begin
        pstate <= 2'd2;
      end
      if (do_wr) begin
        wptr  <= wptr + 1'b1;
        wgray <= b2g(wptr + 1'b1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (do_wr) mem[wptr[AW-1:0]] <= wdata;
  end

  assign full_n    = (wcount != DEPTH);
  assign half_full = (wcount >= HALF);
  assign alm_flag  = (wcount <= {1'b0, ofs_x}) || (wcount >= (DEPTH - {1'b0, ofs_y}));

  assert_full_hold_R2: assert property (@(posedge wclk) disable iff (rst)
    (!full_n && wr_en) |=> $stable(wptr));
  assert_prog_nostore_R6: assert property (@(posedge wclk) disable iff (rst)
    prog_cyc |=> $stable(wptr));
  assert_count_bound_R1: assert property (@(posedge wclk) disable iff (rst)
    wcount <= DEPTH);
  assert_full_flags_R7: assert property (@(posedge wclk) disable iff (rst)
    !full_n |-> (half_full && alm_flag));

  // read side
  logic [PW-1:0] rptr, wg_s1, wg_s2;

  wire [PW-1:0] wptr_r = g2b(wg_s2);
  wire          empty  = (rptr == wptr_r);
  wire          do_rd  = rd_en && !empty;

  always_ff @(posedge rclk or posedge rst) begin
    if (rst) begin
      rptr  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      rdata <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (do_rd) begin
        rdata <= mem[rptr[AW-1:0]];
        rptr  <= rptr + 1'b1;
        rgray <= b2g(rptr + 1'b1);
      end
    end
  end

  assign empty_n = !empty;

  assert_empty_hold_R3: assert property (@(posedge rclk) disable iff (rst)
    (!empty_n && rd_en) |=> ($stable(rptr) && $stable(rdata)));
endmodule

// File: tb/dcfifo_pflag_tb.sv
module dcfifo_pflag_tb_top;
  logic        rst = 1'b1, wclk = 1'b0, rclk = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, prog_n = 1'b1;
  logic [17:0] wdata = '0;
  logic        full_n, half_full, alm_flag, empty_n;
  logic [17:0] rdata;
  int n_chk = 0, n_bad = 0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcfifo_pflag dut_i (
    .rst(rst), .wclk(wclk), .wr_en(wr_en), .prog_n(prog_n), .wdata(wdata),
    .full_n(full_n), .half_full(half_full), .alm_flag(alm_flag),
    .rclk(rclk), .rd_en(rd_en), .rdata(rdata), .empty_n(empty_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (5) @(negedge wclk);
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; prog_n = 1'b1;
    repeat (2) @(negedge wclk);
    rst = 1'b0;
    settle();
  endtask

  task automatic push(input logic [17:0] v);
    @(negedge wclk); wr_en = 1'b1; wdata = v;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
  endtask

  function automatic logic [17:0] pat(input int i);
    return 18'(i * 18'h0137 + 18'h2A5A5);
  endfunction

  task automatic t_reset_state();
    do_reset();
    check(empty_n == 1'b0, "R4 empty_n", empty_n, 0);
    check(full_n == 1'b1, "R4 full_n", full_n, 1);
    check(half_full == 1'b0, "R4 half_full", half_full, 0);
    check(alm_flag == 1'b1, "R4 alm_flag", alm_flag, 1);
    pop();
    check(rdata == 18'h0, "R3 read while empty rdata", rdata, 0);
    check(empty_n == 1'b0, "R3 empty after empty read", empty_n, 0);
  endtask

  task automatic t_fill_drain_default();
    bit ok;
    do_reset();
    for (int i = 1; i <= 256; i++) begin
      push(pat(i));
      if (i == 32)  check(alm_flag == 1'b1, "R9 alm at 32", alm_flag, 1);
      if (i == 33)  check(alm_flag == 1'b0, "R9 alm at 33", alm_flag, 0);
      if (i == 127) check(half_full == 1'b0, "R5 half at 127", half_full, 0);
      if (i == 128) check(half_full == 1'b1, "R5 half at 128", half_full, 1);
      if (i == 223) check(alm_flag == 1'b0, "R9 alm at 223", alm_flag, 0);
      if (i == 224) check(alm_flag == 1'b1, "R9 alm at 224", alm_flag, 1);
      if (i == 255) check(full_n == 1'b1, "R2 full_n at 255", full_n, 1);
    end
    check(full_n == 1'b0, "R2 full_n at 256", full_n, 0);
    push(18'h3FFFF);
    check(full_n == 1'b0, "R2 full after extra write", full_n, 0);
    settle();
    check(empty_n == 1'b1, "R3 empty_n when holding words", empty_n, 1);
    ok = 1'b1;
    for (int i = 1; i <= 256; i++) begin
      pop();
      if (rdata != pat(i)) begin
        ok = 1'b0;
        check(1'b0, "R1 order", rdata, pat(i));
      end
    end
    check(ok, "R1 all 256 words in order", ok, 1);
    settle();
    check(empty_n == 1'b0, "R2 extra write not stored, empty", empty_n, 0);
    check(half_full == 1'b0, "R5 half after drain", half_full, 0);
    pop();
    check(rdata == pat(256), "R3 rdata held on empty read", rdata, pat(256));
  endtask

  task automatic t_prog_two();
    do_reset();
    prog_n = 1'b0;
    push(18'h3FF05);
    push(18'h12A0A);
    prog_n = 1'b1;
    settle();
    check(empty_n == 1'b0, "R6 programming strobes not stored", empty_n, 0);
    for (int i = 1; i <= 246; i++) begin
      push(pat(i));
      if (i == 5)   check(alm_flag == 1'b1, "R6 R7 alm at X=5", alm_flag, 1);
      if (i == 6)   check(alm_flag == 1'b0, "R6 R7 alm at 6", alm_flag, 0);
      if (i == 245) check(alm_flag == 1'b0, "R6 R7 alm at 245", alm_flag, 0);
      if (i == 246) check(alm_flag == 1'b1, "R6 R7 alm at 246", alm_flag, 1);
    end
    settle();
    pop();
    check(rdata == pat(1), "R6 first stored word", rdata, pat(1));
  endtask

  task automatic t_prog_one();
    do_reset();
    prog_n = 1'b0;
    push(18'h2C064);
    prog_n = 1'b1;
    for (int i = 1; i <= 156; i++) begin
      push(pat(i));
      if (i == 100) check(alm_flag == 1'b1, "R8 alm at 100", alm_flag, 1);
      if (i == 101) check(alm_flag == 1'b0, "R8 alm at 101", alm_flag, 0);
      if (i == 155) check(alm_flag == 1'b0, "R8 alm at 155", alm_flag, 0);
      if (i == 156) check(alm_flag == 1'b1, "R8 alm at 156", alm_flag, 1);
    end
    settle();
    pop();
    check(rdata == pat(1), "R8 R6 first word after one strobe", rdata, pat(1));
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_fill_drain_default();
        t_prog_two();
        t_prog_one();
      end
      begin
        repeat (150000) @(posedge wclk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule